// File: doc/BRIEF.md
# Boot-Overlay Chip-Select Decoder

This block produces every chip select of a small 8-bit system with a 16-bit address bus. The system has two address spaces. A memory request is decoded from the top address bits into a select for RAM, for ROM or for one of eight 512-byte peripheral windows. An IO request is decoded from the low byte of the address into one of eight device selects, and each device owns a run of 16 ports. All selects are active low. The decode itself is purely combinational.

A single state bit, the boot overlay, is set by reset. While it is set, memory reads in the lowest 4 KB go to ROM, so the processor finds its start-up code at address zero. Memory writes to that range still reach RAM, so start-up code can copy itself into RAM beneath the overlay. The boot code then writes to IO port 0xFF. That clears the overlay on the same clock edge, and low memory belongs to RAM until the next reset. After that point the map is RAM from 0x0000 to 0xDFFF, peripheral windows from 0xE000 to 0xEFFF and ROM from 0xF000 to 0xFFFF.

Reset is synchronous and active high. The overlay flag is the only register.

Top module: `chip_select_decoder`

## Requirements
- R1: The first clock edge with `rst` high sets the overlay. After reset, a memory read at 0x0000 selects ROM.
- R2: While the overlay is set, a memory read (`rd_n` low) at 0x0000–0x0FFF selects ROM and nothing else.
- R3: While the overlay is set, a memory access to 0x0000–0x0FFF with `rd_n` high selects RAM, so writes land in RAM.
- R4: An IO write (`iorq_n` low, `mreq_n` high, `wr_n` low) to port 0xFF clears the overlay at that clock edge. From the next cycle on, reads at 0x0000–0x0FFF select RAM, and the overlay stays clear until reset.
- R5: With the overlay clear, memory addresses 0x0000–0xDFFF select RAM.
- R6: Memory addresses 0xE000–0xEFFF assert `win_sel_n[i]` low, where i = A11..A9 (bit 0 of the vector is window 0 at 0xE000).
- R7: Memory addresses 0xF000–0xFFFF select ROM in both overlay states, for reads and for writes.
- R8: Memory selects assert only when `mreq_n` is low and `iorq_n` is high.
- R9: An IO request to ports 0x00–0x7F asserts `port_sel_n[A6..A4]` low. Address bits A15..A8 do not affect the IO decode.
- R10: IO ports 0x80–0xFF assert no device select.
- R11: No select asserts when both requests are high, or when both are low. At most one select is low in any cycle.
- R12: An IO read of port 0xFF, or a memory write to 0x00FF, leaves the overlay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the overlay flag |
| rst | input | 1 | Synchronous active-high reset; sets the overlay |
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | IO request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ram_sel_n | output | 1 | RAM select, active low |
| rom_sel_n | output | 1 | ROM select, active low |
| win_sel_n | output | 8 | Peripheral window selects, active low, index A11..A9 |
| port_sel_n | output | 8 | IO device selects, active low, index A6..A4 |

## Verification
On every cycle, assertions check the gating of the two address spaces, the exclusivity of all selects, ROM ownership of the top page, RAM ownership of low writes, and the overlay flag: it clears on a port-0xFF write and stays clear afterwards. Only the bench's scenarios can show that the whole map is correct. The bench sweeps every upper address byte through reads, writes and IO cycles in both overlay states, and compares the result with a behavioural model of the map. The scenarios also cover the near-miss cycles that must not clear the overlay, and show that reset brings the overlay back.

// File: rtl/sel_dec_pkg.sv
package sel_dec_pkg;

    localparam int ADDR_W   = 16;
    localparam int PAGE_W   = 4;
    localparam int PORT_W   = 8;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_MEM   = 2'd1,
        CYC_IO    = 2'd2,
        CYC_CLASH = 2'd3
    } bus_cyc_e;

    typedef struct packed {
        logic ram;
        logic rom;
    } mem_core_sel_s;

    function automatic bus_cyc_e classify_cycle(input logic mreq_n, input logic iorq_n);
        case ({mreq_n, iorq_n})
            2'b01:   return CYC_MEM;
            2'b10:   return CYC_IO;
            2'b00:   return CYC_CLASH;
            default: return CYC_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/sel_overlay_flag.sv
module sel_overlay_flag
    import sel_dec_pkg::*;
#(
    parameter logic [PORT_W-1:0] DISARM_PORT = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cyc_e          cyc,
    input  logic              wr_n,
    input  logic [PORT_W-1:0] port,
    output logic              overlay
);

    logic disarm;
    assign disarm = (cyc == CYC_IO) && !wr_n && (port == DISARM_PORT);

    always_ff @(posedge clk) begin
        if (rst)
            overlay <= 1'b1;
        else if (disarm)
            overlay <= 1'b0;
    end

    // R4: a qualifying IO write clears the flag at that edge
    p_disarm_clears_r4: assert property (@(posedge clk) disable iff (rst)
        ((cyc == CYC_IO) && !wr_n && (port == DISARM_PORT)) |=> !overlay);

    // R4: once clear, the flag stays clear until reset
    p_disarm_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        !overlay |=> !overlay);

    // R12: the flag falls only after an IO write to the disarm port
    p_only_port_write_r12: assert property (@(posedge clk) disable iff (rst)
        (overlay && !((cyc == CYC_IO) && !wr_n && (port == DISARM_PORT))) |=> overlay);

endmodule

// File: rtl/sel_mem_decode.sv
module sel_mem_decode
    import sel_dec_pkg::*;
#(
    parameter int                N_WIN     = 8,
    parameter logic [PAGE_W-1:0] BOOT_PAGE = 4'h0,
    parameter logic [PAGE_W-1:0] WIN_PAGE  = 4'hE,
    parameter logic [PAGE_W-1:0] ROM_PAGE  = 4'hF
) (
    input  bus_cyc_e                cyc,
    input  logic [ADDR_W-1:ADDR_W-PAGE_W-$clog2(N_WIN)] hi_addr,
    input  logic                    rd_n,
    input  logic                    overlay,
    output mem_core_sel_s           core_sel,
    output logic [N_WIN-1:0]        win_sel
);

    localparam int WIN_IDX_W = $clog2(N_WIN);
    localparam int PAGE_LSB  = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0]    page;
    logic [WIN_IDX_W-1:0] win_idx;
    logic                 mem_cyc;
    logic                 boot_read;
    logic                 in_win;

    assign page      = hi_addr[ADDR_W-1:PAGE_LSB];
    assign win_idx   = hi_addr[PAGE_LSB-1:PAGE_LSB-WIN_IDX_W];
    assign mem_cyc   = (cyc == CYC_MEM);
    assign boot_read = overlay && !rd_n && (page == BOOT_PAGE);

    always_comb begin
        core_sel = '0;
        in_win   = 1'b0;
        if (mem_cyc) begin
            if (boot_read || page == ROM_PAGE)
                core_sel.rom = 1'b1;
            else if (page == WIN_PAGE)
                in_win = 1'b1;
            else
                core_sel.ram = 1'b1;
        end
    end

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        assign win_sel[g] = in_win && (win_idx == WIN_IDX_W'(g));
    end

endmodule

// File: rtl/sel_io_decode.sv
module sel_io_decode
    import sel_dec_pkg::*;
#(
    parameter int N_DEV      = 8,
    parameter int DEV_SPAN_W = 4
) (
    input  bus_cyc_e          cyc,
    input  logic [PORT_W-1:0] port,
    output logic [N_DEV-1:0]  dev_sel
);

    localparam int DEV_IDX_W = $clog2(N_DEV);
    localparam int FIELD_TOP = DEV_SPAN_W + DEV_IDX_W;

    logic [DEV_IDX_W-1:0] dev_idx;
    logic                 in_dev_range;

    assign dev_idx      = port[FIELD_TOP-1:DEV_SPAN_W];
    assign in_dev_range = (cyc == CYC_IO) && (port[PORT_W-1:FIELD_TOP] == '0);

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        assign dev_sel[g] = in_dev_range && (dev_idx == DEV_IDX_W'(g));
    end

endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
    import sel_dec_pkg::*;
#(
    parameter int N_WIN = 8,
    parameter int N_DEV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       addr,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              ram_sel_n,
    output logic              rom_sel_n,
    output logic [N_WIN-1:0]  win_sel_n,
    output logic [N_DEV-1:0]  port_sel_n
);

    localparam int WIN_LSB = ADDR_W - PAGE_W - $clog2(N_WIN);

    bus_cyc_e       cyc;
    logic           overlay;
    mem_core_sel_s  core_sel;
    logic [N_WIN-1:0] win_sel;
    logic [N_DEV-1:0] dev_sel;
    logic           unused_addr_bits;

    assign cyc              = classify_cycle(mreq_n, iorq_n);
    assign unused_addr_bits = ^addr[WIN_LSB-1:PORT_W];

    sel_overlay_flag #(.DISARM_PORT(8'hFF)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .cyc     (cyc),
        .wr_n    (wr_n),
        .port    (addr[PORT_W-1:0]),
        .overlay (overlay)
    );

    sel_mem_decode #(.N_WIN(N_WIN)) u_mem (
        .cyc      (cyc),
        .hi_addr  (addr[ADDR_W-1:WIN_LSB]),
        .rd_n     (rd_n),
        .overlay  (overlay),
        .core_sel (core_sel),
        .win_sel  (win_sel)
    );

    sel_io_decode #(.N_DEV(N_DEV), .DEV_SPAN_W(4)) u_io (
        .cyc     (cyc),
        .port    (addr[PORT_W-1:0]),
        .dev_sel (dev_sel)
    );

    assign ram_sel_n  = ~core_sel.ram;
    assign rom_sel_n  = ~core_sel.rom;
    assign win_sel_n  = ~win_sel;
    assign port_sel_n = ~dev_sel;

    // R11: never more than one select low
    p_exclusive_r11: assert property (@(posedge clk) disable iff (rst)
        $countones({~ram_sel_n, ~rom_sel_n, ~win_sel_n, ~port_sel_n}) <= 1);

    // R11: idle and clashing requests select nothing
    p_no_request_r11: assert property (@(posedge clk) disable iff (rst)
        (mreq_n == iorq_n) |-> (&{ram_sel_n, rom_sel_n, win_sel_n, port_sel_n}));

    // R8: memory selects need a lone memory request
    p_mem_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !(!mreq_n && iorq_n) |-> (ram_sel_n && rom_sel_n && (&win_sel_n)));

    // R9: device selects need a lone IO request
    p_io_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !(mreq_n && !iorq_n) |-> (&port_sel_n));

    // R7: top page is ROM in every state
    p_rom_high_r7: assert property (@(posedge clk) disable iff (rst)
        (!mreq_n && iorq_n && addr[15:12] == 4'hF) |-> !rom_sel_n);

    // R3: non-read access to the boot page always lands in RAM
    p_low_write_ram_r3: assert property (@(posedge clk) disable iff (rst)
        (!mreq_n && iorq_n && rd_n && addr[15:12] == 4'h0) |-> !ram_sel_n);

    // R10: upper half of IO space selects no device
    p_high_ports_r10: assert property (@(posedge clk) disable iff (rst)
        (!iorq_n && addr[7]) |-> (&port_sel_n));

endmodule

// File: tb/chip_select_decoder_tb_top.sv
`timescale 1ns/1ps
module chip_select_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic        mreq_n = 1'b1;
    logic        iorq_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        ram_sel_n, rom_sel_n;
    logic [7:0]  win_sel_n, port_sel_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit ref_ovl = 1'b1;

    always #2 clk = ~clk;

    chip_select_decoder dut_i (
        .clk(clk), .rst(rst), .addr(addr), .mreq_n(mreq_n), .iorq_n(iorq_n),
        .rd_n(rd_n), .wr_n(wr_n), .ram_sel_n(ram_sel_n), .rom_sel_n(rom_sel_n),
        .win_sel_n(win_sel_n), .port_sel_n(port_sel_n)
    );

    // bit0 RAM, bit1 ROM, bits 9:2 windows, bits 17:10 IO devices (active high)
    function automatic logic [17:0] model(input int a, input bit mq_n, input bit io_n,
                                          input bit r_n, input bit ovl);
        logic [17:0] v = '0;
        int p;
        if (!mq_n && io_n) begin
            if (ovl && !r_n && a < 4096)  v[1] = 1'b1;
            else if (a < 'hE000)          v[0] = 1'b1;
            else if (a < 'hF000)          v[2 + (a - 'hE000) / 512] = 1'b1;
            else                          v[1] = 1'b1;
        end else if (mq_n && !io_n) begin
            p = a % 256;
            if (p < 128) v[10 + p / 16] = 1'b1;
        end
        return v;
    endfunction

    function automatic string tag_for(input int a, input bit mq_n, input bit io_n,
                                      input bit r_n, input bit ovl);
        if (mq_n == io_n) return "R11";
        if (!io_n) return ((a % 256) < 128) ? "R9" : "R10";
        if (a >= 'hF000) return "R7";
        if (a >= 'hE000) return "R6";
        if (a < 4096 && ovl) return r_n ? "R3" : "R2";
        if (a < 4096 && !r_n) return "R4";
        return "R5";
    endfunction

    task automatic apply(input int a, input bit mq_n, input bit io_n, input bit r_n,
                         input bit w_n, input string tag);
        logic [17:0] exp_v, act_v;
        @(negedge clk);
        addr = a[15:0]; mreq_n = mq_n; iorq_n = io_n; rd_n = r_n; wr_n = w_n;
        #1;
        exp_v = model(a, mq_n, io_n, r_n, ref_ovl);
        act_v = ~{port_sel_n, win_sel_n, rom_sel_n, ram_sel_n};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s addr=%h mreq_n=%b iorq_n=%b rd_n=%b wr_n=%b actual=%b expected=%b",
                     tag, a[15:0], mq_n, io_n, r_n, w_n, act_v, exp_v);
        end
        @(posedge clk);
        if (mq_n && !io_n && !w_n && (a % 256) == 255) ref_ovl = 1'b0;
    endtask

    task automatic idle_bus();
        @(negedge clk);
        mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic sweep(input bit avoid_disarm);
        for (int u = 0; u < 256; u++) begin
            int lo = (u * 37 + 11) % 256;
            int a = u * 256 + lo;
            int aio = (avoid_disarm && lo == 255) ? a - 1 : a;
            apply(a,   1'b0, 1'b1, 1'b0, 1'b1, tag_for(a, 1'b0, 1'b1, 1'b0, ref_ovl));
            apply(a,   1'b0, 1'b1, 1'b1, 1'b0, tag_for(a, 1'b0, 1'b1, 1'b1, ref_ovl));
            apply(aio, 1'b1, 1'b0, 1'b0, 1'b1, tag_for(aio, 1'b1, 1'b0, 1'b0, ref_ovl));
            apply(aio, 1'b1, 1'b0, 1'b1, 1'b0, tag_for(aio, 1'b1, 1'b0, 1'b1, ref_ovl));
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        ref_ovl = 1'b1;

        // R1: reset state, boot read at zero hits ROM; idle bus selects nothing
        apply('h0000, 1'b0, 1'b1, 1'b0, 1'b1, "R1");
        apply('h1234, 1'b1, 1'b1, 1'b0, 1'b1, "R11");
        // R11: clashing requests select nothing
        apply('hE200, 1'b0, 1'b0, 1'b0, 1'b1, "R11");
        // R8: IO cycle at a ROM-page address asserts no memory select
        apply('hF010, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        // R2 / R3 boot page edges
        apply('h0FFF, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
        apply('h1000, 1'b0, 1'b1, 1'b0, 1'b1, "R2");
        apply('h0FFF, 1'b0, 1'b1, 1'b1, 1'b0, "R3");

        // R12: near-miss cycles must not clear the overlay
        apply('h00FF, 1'b1, 1'b0, 1'b0, 1'b1, "R12");
        apply('h00FF, 1'b0, 1'b1, 1'b1, 1'b0, "R12");
        apply('h0000, 1'b0, 1'b1, 1'b0, 1'b1, "R12");

        sweep(1'b1);

        // R6 window edges
        apply('hE1FF, 1'b0, 1'b1, 1'b0, 1'b1, "R6");
        apply('hEE00, 1'b0, 1'b1, 1'b1, 1'b0, "R6");
        // R9 / R10 port edges, upper address byte set
        apply('hAB7F, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
        apply('h5580, 1'b1, 1'b0, 1'b1, 1'b0, "R10");

        // R4: disarm, then low memory reads go to RAM
        apply('h12FF, 1'b1, 1'b0, 1'b1, 1'b0, "R4");
        apply('h0000, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
        apply('h0ABC, 1'b0, 1'b1, 1'b0, 1'b1, "R4");
        apply('hDFFF, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
        apply('hFFFF, 1'b0, 1'b1, 1'b0, 1'b1, "R7");

        sweep(1'b0);

        // R1: reset brings the overlay back
        idle_bus();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        ref_ovl = 1'b1;
        apply('h0000, 1'b0, 1'b1, 1'b0, 1'b1, "R1");
        apply('h0800, 1'b0, 1'b1, 1'b0, 1'b1, "R1");

        idle_bus();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule